// File: doc/BRIEF.md
# Slave-mode multi-format serial audio transmitter

This block sends stereo sample pairs, MSB first, on one serial data line to an external receiver. The receiver drives both the bit clock and the frame sync, so the block is always a clock slave. Both inputs pass through a synchronizer into the faster system clock domain. Every data-line update is then made on a system clock edge, one synchronized bit-clock edge at a time.

Static configuration inputs select the framing format: I2S, left-justified, or a DSP-style single-pulse frame with a selectable data delay. They also select the word length and which bit-clock edge the receiver samples on. At the start of each frame the block takes one left/right pair from an internal source through a valid/ready handshake. If no pair is offered, it sends zeros and flags an underrun. Spare bit-clock cycles after a word's LSB keep the line low. Alignment comes back at the next frame-sync event, so any slot length at least as long as the word works.

The system clock must run at least eight times faster than the bit clock, with each bit-clock level lasting at least four system cycles. The host changes frame sync on the launch edge, the bit-clock edge opposite the capture edge. Samples are SAMPLE_W bits wide. The transmitted word is their top W bits.

Top module: `aud_tx`

## Requirements
- R1: The data line changes only as a result of a launch edge. The launch edge is the bit-clock edge opposite the capture edge. Each change shows on sdata_o three system clock edges after the bit-clock change reaches bclk_i. Otherwise sdata_o holds its value.
- R2: A word is the top W bits of its sample, sent from bit SAMPLE_W-1 downward, one bit per bit-clock cycle.
- R3: Format code 0 (I2S): every frame-sync change is an event. Frame sync low marks the left word and high marks the right word. The MSB is sampled at the second capture edge after the change.
- R4: Format code 1 (left-justified): every frame-sync change is an event. Frame sync high marks the left word and low marks the right word. The MSB is sampled at the first capture edge after the change.
- R5: Format codes 2 and 3 (DSP): only a rising frame-sync edge is an event, and a falling edge has no effect. The left word is followed at once by the right word. cfg_dsp_late_i=0 puts the left MSB at the first capture edge after the rise, and 1 puts it at the second.
- R6: cfg_wlen_i codes 0, 1, 2 and 3 select word lengths of 8, 16, 20 and 24 bits.
- R7: Bit-clock cycles after a word's LSB carry a low data line until the next word starts. A word may also start directly after the previous LSB.
- R8: cfg_cap_fall_i=0 makes the rising edge the capture edge, and 1 makes the falling edge the capture edge. The launch edge is always the opposite edge.
- R9: pair_ready_o is high for exactly one system cycle per frame start, and is low out of reset. A frame start is a left-word event, or a DSP event. The pair is taken when pair_valid_i is also high.
- R10: At a frame start with pair_valid_i low, underrun_o is high together with pair_ready_o, and both words of that frame are sent as zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bclk_i | input | 1 | Bit clock from the host |
| fsync_i | input | 1 | Frame sync from the host |
| cfg_fmt_i | input | 2 | Format: 0 I2S, 1 left-justified, 2/3 DSP |
| cfg_wlen_i | input | 2 | Word length code: 8/16/20/24 bits |
| cfg_cap_fall_i | input | 1 | 1 selects falling-edge capture |
| cfg_dsp_late_i | input | 1 | DSP: 1 delays the MSB by one bit clock |
| pair_valid_i | input | 1 | Source offers a pair |
| pair_ready_o | output | 1 | Pair taken this cycle (frame start) |
| left_i | input | SAMPLE_W | Left sample |
| right_i | input | SAMPLE_W | Right sample |
| sdata_o | output | 1 | Serial data |
| underrun_o | output | 1 | Frame started with no pair available |

## Verification
In a zero-delay format, a frame start can fetch a pair and load the shifter in the same system cycle, so the fetched bits must appear on the first word. Exact-fill slots in I2S, left-justified and DSP configurations are used to provoke this. There, the LSB of one word and the MSB of the next fall on adjacent bit clocks, and an event's load meets the shift of the previous word. The bench models each expected bit per bit-clock slot from the frame-sync pattern it drives. It compares the data line, ready and underrun on every system clock inside the slot's stable window.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;
  typedef enum logic [1:0] {
    FMT_I2S  = 2'd0,
    FMT_LJ   = 2'd1,
    FMT_DSP  = 2'd2,
    FMT_DSP2 = 2'd3
  } fmt_e;

  typedef enum logic [1:0] {
    LD_LEFT  = 2'd0,
    LD_RIGHT = 2'd1,
    LD_BOTH  = 2'd2
  } ld_e;

  function automatic logic [5:0] wlen_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 6'd8;
      2'd1:    return 6'd16;
      2'd2:    return 6'd20;
      default: return 6'd24;
    endcase
  endfunction
endpackage

// File: rtl/aud_tx_sync.sv
module aud_tx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_i,
  input  logic fsync_i,
  input  logic cap_fall_i,
  output logic launch_o,
  output logic fs_o
);
  localparam int NSIG = 2;

  logic [NSIG-1:0]   raw;
  logic [STAGES-1:0] chain [NSIG];
  logic              bclk_prev_q;

  assign raw = {fsync_i, bclk_i};

  for (genvar g = 0; g < NSIG; g++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain[g] <= '0;
      else         chain[g] <= {chain[g][STAGES-2:0], raw[g]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bclk_prev_q <= 1'b0;
    else         bclk_prev_q <= chain[0][STAGES-1];
  end

  // launch edge is the one opposite the capture edge
  assign launch_o = cap_fall_i ? (chain[0][STAGES-1] & ~bclk_prev_q)
                               : (~chain[0][STAGES-1] & bclk_prev_q);
  assign fs_o = chain[1][STAGES-1];
endmodule

// File: rtl/aud_tx_frame.sv
module aud_tx_frame
  import aud_tx_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  launch_i,
  input  logic                  fs_i,
  input  logic [1:0]            fmt_i,
  input  logic [1:0]            wlen_i,
  input  logic                  dsp_late_i,
  input  logic                  valid_i,
  input  logic [SAMPLE_W-1:0]   left_i,
  input  logic [SAMPLE_W-1:0]   right_i,
  output logic                  ready_o,
  output logic                  underrun_o,
  output logic                  load_o,
  output logic [2*SAMPLE_W-1:0] load_vec_o
);
  localparam int VW = 2 * SAMPLE_W;

  fmt_e                fmt;
  logic                is_dsp, delayed;
  logic                fs_last_q;
  logic                chg, evt, left_evt, frame_start;
  logic                pend_q;
  ld_e                 pend_kind_q, evt_kind, ld_kind;
  logic [SAMPLE_W-1:0] l_q, r_q, l_use, r_use, mask;
  logic [5:0]          wl;

  assign fmt     = fmt_e'(fmt_i);
  assign is_dsp  = (fmt == FMT_DSP) || (fmt == FMT_DSP2);
  assign delayed = (fmt == FMT_I2S) || (is_dsp && dsp_late_i);
  assign wl      = wlen_bits(wlen_i);
  assign mask    = ~({SAMPLE_W{1'b1}} >> wl);

  assign chg         = launch_i && (fs_i != fs_last_q);
  assign evt         = is_dsp ? (chg && fs_i) : chg;
  assign left_evt    = (fmt == FMT_I2S) ? ~fs_i : fs_i;
  assign frame_start = evt && (is_dsp || left_evt);
  assign evt_kind    = is_dsp ? LD_BOTH : (left_evt ? LD_LEFT : LD_RIGHT);

  assign ready_o    = frame_start;
  assign underrun_o = frame_start && !valid_i;

  // a zero-delay load in the fetch cycle uses the incoming pair directly
  assign l_use = frame_start ? (valid_i ? left_i  : '0) : l_q;
  assign r_use = frame_start ? (valid_i ? right_i : '0) : r_q;

  always_comb begin
    load_o  = 1'b0;
    ld_kind = evt_kind;
    if (launch_i && pend_q) begin
      load_o  = 1'b1;
      ld_kind = pend_kind_q;
    end else if (evt && !delayed) begin
      load_o  = 1'b1;
    end
  end

  always_comb begin
    case (ld_kind)
      LD_LEFT:  load_vec_o = {l_use & mask, {SAMPLE_W{1'b0}}};
      LD_RIGHT: load_vec_o = {r_use & mask, {SAMPLE_W{1'b0}}};
      default:  load_vec_o = {l_use & mask, {SAMPLE_W{1'b0}}}
                           | ({r_use & mask, {SAMPLE_W{1'b0}}} >> wl);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_last_q   <= 1'b0;
      pend_q      <= 1'b0;
      pend_kind_q <= LD_LEFT;
      l_q         <= '0;
      r_q         <= '0;
    end else begin
      if (launch_i) begin
        fs_last_q <= fs_i;
        pend_q    <= evt && delayed;
        if (evt && delayed) pend_kind_q <= evt_kind;
      end
      if (frame_start) begin
        l_q <= l_use;
        r_q <= r_use;
      end
    end
  end

  logic unused_w;
  assign unused_w = ^load_vec_o[VW-1:VW-1];
endmodule

// File: rtl/aud_tx_shift.sv
module aud_tx_shift #(
  parameter int SAMPLE_W = 24
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  launch_i,
  input  logic                  load_i,
  input  logic [2*SAMPLE_W-1:0] load_vec_i,
  output logic                  sdata_o
);
  localparam int VW = 2 * SAMPLE_W;

  logic          sd_q;
  logic [VW-2:0] sh_q;

  // zero fill drives the line low after the LSB
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sd_q <= 1'b0;
      sh_q <= '0;
    end else if (launch_i) begin
      if (load_i) begin
        sd_q <= load_vec_i[VW-1];
        sh_q <= load_vec_i[VW-2:0];
      end else begin
        sd_q <= sh_q[VW-2];
        sh_q <= {sh_q[VW-3:0], 1'b0};
      end
    end
  end

  assign sdata_o = sd_q;
endmodule

// File: rtl/aud_tx.sv
module aud_tx #(
  parameter int SAMPLE_W    = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bclk_i,
  input  logic                fsync_i,
  input  logic [1:0]          cfg_fmt_i,
  input  logic [1:0]          cfg_wlen_i,
  input  logic                cfg_cap_fall_i,
  input  logic                cfg_dsp_late_i,
  input  logic                pair_valid_i,
  output logic                pair_ready_o,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                sdata_o,
  output logic                underrun_o
);
  logic                  launch_w, fs_w, load_w;
  logic [2*SAMPLE_W-1:0] load_vec_w;

  aud_tx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bclk_i    (bclk_i),
    .fsync_i   (fsync_i),
    .cap_fall_i(cfg_cap_fall_i),
    .launch_o  (launch_w),
    .fs_o      (fs_w)
  );

  aud_tx_frame #(.SAMPLE_W(SAMPLE_W)) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .launch_i  (launch_w),
    .fs_i      (fs_w),
    .fmt_i     (cfg_fmt_i),
    .wlen_i    (cfg_wlen_i),
    .dsp_late_i(cfg_dsp_late_i),
    .valid_i   (pair_valid_i),
    .left_i    (left_i),
    .right_i   (right_i),
    .ready_o   (pair_ready_o),
    .underrun_o(underrun_o),
    .load_o    (load_w),
    .load_vec_o(load_vec_w)
  );

  aud_tx_shift #(.SAMPLE_W(SAMPLE_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .launch_i  (launch_w),
    .load_i    (load_w),
    .load_vec_i(load_vec_w),
    .sdata_o   (sdata_o)
  );
endmodule

// File: rtl/aud_tx_chk.sv
module aud_tx_chk #(
  parameter int SAMPLE_W = 24
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [1:0]          cfg_fmt_i,
  input logic                pair_valid_i,
  input logic                pair_ready_o,
  input logic [SAMPLE_W-1:0] left_i,
  input logic                sdata_o,
  input logic                underrun_o,
  input logic                launch_i
);
  p_sdata_on_launch_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdata_o) |-> $past(launch_i));

  p_ready_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_ready_o |=> !pair_ready_o);

  p_ready_on_launch_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_ready_o |-> launch_i);

  p_underrun_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |-> (pair_ready_o && !pair_valid_i));

  p_underrun_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun_o && cfg_fmt_i == 2'd1) |=> !sdata_o);

  p_lj_msb_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_ready_o && pair_valid_i && cfg_fmt_i == 2'd1)
      |=> (sdata_o == $past(left_i[SAMPLE_W-1])));
endmodule

bind aud_tx aud_tx_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_fmt_i   (cfg_fmt_i),
  .pair_valid_i(pair_valid_i),
  .pair_ready_o(pair_ready_o),
  .left_i      (left_i),
  .sdata_o     (sdata_o),
  .underrun_o  (underrun_o),
  .launch_i    (launch_w)
);

// File: tb/tb_aud_tx.sv
`timescale 1ns/1ps
module tb_aud_tx;
  localparam int SW = 24;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          bclk_i = 1'b1;
  logic          fsync_i = 1'b0;
  logic [1:0]    cfg_fmt_i = 2'd0;
  logic [1:0]    cfg_wlen_i = 2'd1;
  logic          cfg_cap_fall_i = 1'b0;
  logic          cfg_dsp_late_i = 1'b0;
  logic          pair_valid_i = 1'b0;
  logic          pair_ready_o;
  logic [SW-1:0] left_i = '0;
  logic [SW-1:0] right_i = '0;
  logic          sdata_o;
  logic          underrun_o;

  always #2.5 clk_i = ~clk_i;

  aud_tx dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .bclk_i(bclk_i), .fsync_i(fsync_i),
    .cfg_fmt_i(cfg_fmt_i), .cfg_wlen_i(cfg_wlen_i),
    .cfg_cap_fall_i(cfg_cap_fall_i), .cfg_dsp_late_i(cfg_dsp_late_i),
    .pair_valid_i(pair_valid_i), .pair_ready_o(pair_ready_o),
    .left_i(left_i), .right_i(right_i), .sdata_o(sdata_o),
    .underrun_o(underrun_o)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;
  string tag;

  logic [SW-1:0] ql[$];
  logic [SW-1:0] qr[$];
  bit src_en;

  bit fs_last;
  int slot;
  bit exp_b [0:2047];
  logic [SW-1:0] cur_l, cur_r;

  task automatic src_upd();
    pair_valid_i = src_en && (ql.size() > 0);
    left_i  = (ql.size() > 0) ? ql[0] : '0;
    right_i = (qr.size() > 0) ? qr[0] : '0;
  endtask

  task automatic push_pair(input logic [SW-1:0] l, input logic [SW-1:0] r);
    ql.push_back(l);
    qr.push_back(r);
    src_upd();
  endtask

  function automatic int wbits(input logic [1:0] c);
    case (c)
      2'd0: return 8;
      2'd1: return 16;
      2'd2: return 20;
      default: return 24;
    endcase
  endfunction

  task automatic chk(input string what, input logic act, input logic expv);
    n_vec++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b (slot %0d)", tag, what, act, expv, slot);
    end
  endtask

  task automatic put_word(input int at, input logic [SW-1:0] w, input int nb);
    for (int i = 0; i < nb; i++) exp_b[at + i] = w[SW-1-i];
  endtask

  // one bit-clock period: launch half then capture half, 16 system cycles
  task automatic do_slot(input bit f);
    bit chg, evt, start, is_left, v;
    int d, nb;
    @(posedge clk_i); #1;
    bclk_i  = cfg_cap_fall_i ? 1'b1 : 1'b0;
    fsync_i = f;
    nb  = wbits(cfg_wlen_i);
    chg = (f != fs_last);
    start = 0; v = 0; d = 0;
    if (cfg_fmt_i == 2'd0) begin
      evt = chg; is_left = !f; d = 1;
    end else if (cfg_fmt_i == 2'd1) begin
      evt = chg; is_left = f; d = 0;
    end else begin
      evt = chg && f; is_left = 1; d = cfg_dsp_late_i ? 1 : 0;
    end
    if (evt && is_left) begin
      start = 1;
      v = src_en && (ql.size() > 0);
      cur_l = v ? ql[0] : '0;
      cur_r = v ? qr[0] : '0;
    end
    if (evt) begin
      if (cfg_fmt_i >= 2'd2) begin
        put_word(slot + d, cur_l, nb);
        put_word(slot + d + nb, cur_r, nb);
      end else begin
        put_word(slot + d, is_left ? cur_l : cur_r, nb);
      end
    end
    for (int ph = 0; ph < 16; ph++) begin
      @(negedge clk_i);
      chk("ready R9", pair_ready_o, start && ph == 2);
      chk("underrun R10", underrun_o, start && ph == 2 && !v);
      if (ph >= 3) chk("sdata R1", sdata_o, exp_b[slot]);
      if (ph == 2 && start && v) begin
        @(posedge clk_i); #1;
        void'(ql.pop_front());
        void'(qr.pop_front());
        src_upd();
      end
      if (ph == 7) begin
        @(posedge clk_i); #1;
        bclk_i = cfg_cap_fall_i ? 1'b0 : 1'b1;
      end
    end
    fs_last = f;
    slot++;
  endtask

  task automatic start_test(input string t, input logic [1:0] fmt, input logic [1:0] wl,
                            input logic capf, input logic late);
    tag = t;
    @(posedge clk_i); #1;
    rst_ni = 1'b0;
    cfg_fmt_i = fmt; cfg_wlen_i = wl; cfg_cap_fall_i = capf; cfg_dsp_late_i = late;
    bclk_i = capf ? 1'b0 : 1'b1;
    fsync_i = 1'b0;
    ql.delete(); qr.delete(); src_en = 1; src_upd();
    fs_last = 0; slot = 0; cur_l = '0; cur_r = '0;
    foreach (exp_b[i]) exp_b[i] = 0;
    repeat (3) @(negedge clk_i);
    chk("reset sdata R9", sdata_o, 1'b0);
    chk("reset ready R9", pair_ready_o, 1'b0);
    chk("reset underrun R10", underrun_o, 1'b0);
    @(posedge clk_i); #1;
    rst_ni = 1'b1;
    repeat (4) @(posedge clk_i);
  endtask

  task automatic lr_frames(input int half, input int nfr, input bit left_lvl);
    for (int k = 0; k < nfr; k++) begin
      for (int s = 0; s < half; s++) do_slot(left_lvl);
      for (int s = 0; s < half; s++) do_slot(!left_lvl);
    end
  endtask

  task automatic dsp_frames(input int len, input int nfr);
    for (int k = 0; k < nfr; k++)
      for (int s = 0; s < len; s++) do_slot(s == 0);
  endtask

  initial begin
    // I2S, 16-bit words in 32-slot halves: idle cycles after LSB
    start_test("R2 R3 R6 R7", 2'd0, 2'd1, 1'b0, 1'b0);
    for (int k = 0; k < 4; k++) push_pair(24'hA5C3F1 ^ (k * 24'h13579B), 24'h3C96E7 + k * 24'h0F1E2D);
    for (int s = 0; s < 2; s++) do_slot(1'b1);
    lr_frames(32, 3, 1'b0);

    // I2S, 24-bit words filling 24-slot halves exactly
    start_test("R3 R6 R7", 2'd0, 2'd3, 1'b0, 1'b0);
    push_pair(24'hF0F0A5, 24'h5A0F3C);
    push_pair(24'h81C37E, 24'hE71824);
    for (int s = 0; s < 2; s++) do_slot(1'b1);
    lr_frames(24, 2, 1'b0);

    // left-justified, 20-bit, falling-edge capture
    start_test("R4 R6 R8", 2'd1, 2'd2, 1'b1, 1'b0);
    push_pair(24'hD2B4C6, 24'h6B9D2F);
    push_pair(24'h1F2E3D, 24'hC4A5B6);
    lr_frames(24, 2, 1'b1);

    // left-justified, 8-bit exact fill
    start_test("R4 R6 R7", 2'd1, 2'd0, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) push_pair(24'h96A500 + k * 24'h11_0000, 24'h3CC300 - k * 24'h21_0000);
    lr_frames(8, 3, 1'b1);

    // DSP, one-cycle delay, 16-bit, 40-slot frames
    start_test("R5 R6 R7", 2'd2, 2'd1, 1'b0, 1'b1);
    for (int k = 0; k < 3; k++) push_pair(24'hB1E2D3 + k * 24'h010203, 24'h4A7B8C ^ (k * 24'h55AA55));
    dsp_frames(40, 3);

    // DSP code 3, zero delay, 24-bit, frame exactly two words
    start_test("R5 R6 R7", 2'd3, 2'd3, 1'b1, 1'b0);
    push_pair(24'hC3A55A, 24'h0FF0E1);
    push_pair(24'h7E8142, 24'hA9B8C7);
    dsp_frames(48, 2);

    // underrun: only one pair queued for three frames
    start_test("R9 R10", 2'd0, 2'd1, 1'b0, 1'b0);
    push_pair(24'hE1D2C3, 24'hB4A596);
    for (int s = 0; s < 2; s++) do_slot(1'b1);
    lr_frames(20, 3, 1'b0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog %s: actual running expected finished", tag);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule